// File: doc/BRIEF.md
# Adaptive DC Offset Correction Loop

This block removes a slowly varying DC offset from a stream of signed ADC samples. A first-order leaky integrator follows the mean of the incoming samples. Its time constant is a power-of-two number of clock cycles, chosen by a 4-bit code. The integer part of the integrator is the offset estimate, and that estimate is subtracted from each sample. The corrected sample appears one clock after its input, saturated to the sample width.

Correction acts only when the enable bit is set and the low-latency flag is clear. In any other state the samples pass through unchanged, with the same one-cycle latency, and the integrator is cleared. A freeze bit stops the integrator but keeps subtracting the last estimate. The estimate is limited to a programmable number of LSBs, which bounds how much offset the loop can take out.

Top module: `dc_offset_loop`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_data` and `offset_est` are all zero. The time-constant code register resets to 0.
- R2: Correction is active only when `corr_en` = 1 and `low_lat` = 0. When it is inactive, `out_data` equals the `in_data` of the previous cycle, and `offset_est` reads 0 one cycle later.
- R3: When correction is active, each valid sample with `freeze` = 0 updates the accumulator by (sample·2^F − acc) >>> (TC_BASE + code). Here F = TC_BASE + 11 fractional bits, and the code is the latched one. `offset_est` is floor(acc / 2^F).
- R4: When correction is active, `out_data` equals `in_data` minus the `offset_est` that held on the input's cycle, and it appears one cycle later.
- R5: While `freeze` = 1 and correction is active, `offset_est` does not change. It is still subtracted from every sample.
- R6: Codes 0 to 11 are latched and select a shift of TC_BASE + code. Codes 12 to 15 are ignored, and the last latched code stays in effect.
- R7: The accumulator is clamped so that `offset_est` stays within −LIMIT to +LIMIT.
- R8: The corrected output saturates to the signed SW-bit range, −2^(SW−1) to 2^(SW−1)−1, and never wraps.
- R9: A constant offset plus zero-mean noise of ±1 LSB, applied for more than 5 time constants, leaves `offset_est` within 1 LSB of the offset.
- R10: `out_valid` equals `in_valid` delayed by one cycle. Cycles with `in_valid` = 0 do not change the estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | SW | Signed input sample |
| corr_en | input | 1 | Correction enable |
| freeze | input | 1 | Hold the current estimate |
| low_lat | input | 1 | Low-latency mode; blocks correction while high |
| tc_code | input | 4 | Time-constant code (12–15 reserved) |
| out_valid | output | 1 | Strobe for the corrected sample |
| out_data | output | SW | Signed corrected sample |
| offset_est | output | SW | Current signed offset estimate |

## Verification
The bench builds the block with SW = 12, TC_BASE = 2 and LIMIT = 100, so code 0 gives a time constant of 4 cycles and code 3 gives 32. Convergence over many time constants, the clamp and the reserved-code hold can then all be reached in a few hundred cycles. With a 12-bit sample and a limit of 100, saturation at both rails is also easy to provoke. The accumulator keeps the same fixed-point layout as at full scale, only with fewer fractional bits.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;
  localparam int unsigned NUM_CODES = 12;
  localparam int unsigned CODE_W    = 4;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c < CODE_W'(NUM_CODES);
  endfunction
endpackage

// File: rtl/dcoc_tc_decode.sv
module dcoc_tc_decode
  import dcoc_pkg::*;
#(
  parameter int unsigned TC_BASE = 20,
  parameter int unsigned SHW     = $clog2(TC_BASE + NUM_CODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] tc_code,
  output logic [SHW-1:0]    shift
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)                code_q <= '0;
    else if (code_ok(tc_code)) code_q <= tc_code;
  end

  assign shift = SHW'(TC_BASE) + SHW'(code_q);

  p_reserved_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !code_ok(tc_code) |=> $stable(code_q));
  p_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
    code_q < CODE_W'(NUM_CODES));
endmodule

// File: rtl/dcoc_estimator.sv
module dcoc_estimator #(
  parameter int unsigned SW    = 16,
  parameter int unsigned FRAC  = 31,
  parameter int unsigned LIMIT = 64,
  parameter int unsigned SHW   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 update,
  input  logic signed [SW-1:0] sample,
  input  logic [SHW-1:0]       shift,
  output logic signed [SW-1:0] est_q
);
  localparam int unsigned AW = SW + 2 + FRAC;
  localparam logic signed [AW-1:0] HI = $signed(AW'(LIMIT)) <<< FRAC;
  localparam logic signed [AW-1:0] LO = -HI;

  logic signed [AW-1:0] acc_q, acc_nx, xs, delta, sum, ipart;

  always_comb begin
    xs    = {{(AW-SW){sample[SW-1]}}, sample};
    delta = (xs <<< FRAC) - acc_q;
    sum   = acc_q + (delta >>> shift);
    if (!active)        acc_nx = '0;
    else if (!update)   acc_nx = acc_q;
    else if (sum > HI)  acc_nx = HI;
    else if (sum < LO)  acc_nx = LO;
    else                acc_nx = sum;
    ipart = acc_nx >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      est_q <= '0;
    end else begin
      acc_q <= acc_nx;
      est_q <= ipart[SW-1:0];
    end
  end

  p_clear_off_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> (acc_q == '0 && est_q == '0));
  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !update) |=> $stable(acc_q));
  p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_q <= HI) && (acc_q >= LO));
  p_est_range_r7: assert property (@(posedge clk) disable iff (rst)
    ($signed(est_q) <= $signed(SW'(LIMIT))) && ($signed(est_q) >= -$signed(SW'(LIMIT))));
endmodule

// File: rtl/dcoc_apply.sv
module dcoc_apply #(
  parameter int unsigned SW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_data,
  input  logic signed [SW-1:0] est,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_data
);
  localparam logic signed [SW-1:0] MAXV = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {1'b1, {(SW-1){1'b0}}};

  logic signed [SW:0]   diff;
  logic signed [SW-1:0] corr;

  always_comb begin
    diff = {in_data[SW-1], in_data} - {est[SW-1], est};
    if (diff[SW] != diff[SW-1]) corr = diff[SW] ? MINV : MAXV;
    else                        corr = diff[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= active ? corr : in_data;
    end
  end

  p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> out_data == $past(in_data));
  p_valid_delay_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));
endmodule

// File: rtl/dc_offset_loop.sv
module dc_offset_loop
  import dcoc_pkg::*;
#(
  parameter int unsigned SW      = 16,
  parameter int unsigned TC_BASE = 20,
  parameter int unsigned LIMIT   = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_data,
  input  logic                 corr_en,
  input  logic                 freeze,
  input  logic                 low_lat,
  input  logic [3:0]           tc_code,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_data,
  output logic signed [SW-1:0] offset_est
);
  localparam int unsigned FRAC = TC_BASE + NUM_CODES - 1;
  localparam int unsigned SHW  = $clog2(TC_BASE + NUM_CODES);

  logic           active;
  logic [SHW-1:0] shift;

  assign active = corr_en & ~low_lat;

  dcoc_tc_decode #(.TC_BASE(TC_BASE), .SHW(SHW)) u_tc (
    .clk(clk), .rst(rst), .tc_code(tc_code), .shift(shift)
  );

  dcoc_estimator #(.SW(SW), .FRAC(FRAC), .LIMIT(LIMIT), .SHW(SHW)) u_est (
    .clk(clk), .rst(rst), .active(active), .update(in_valid & ~freeze),
    .sample(in_data), .shift(shift), .est_q(offset_est)
  );

  dcoc_apply #(.SW(SW)) u_app (
    .clk(clk), .rst(rst), .active(active), .in_valid(in_valid),
    .in_data(in_data), .est(offset_est),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: tb/sim_dc_offset_loop.sv
`timescale 1ns/1ps
module sim_dc_offset_loop;
  localparam int SW = 12, TCB = 2, LIM = 100, FR = TCB + 11;
  localparam int MAXV = 2047, MINV = -2048;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, corr_en = 1'b0, freeze = 1'b0, low_lat = 1'b1;
  logic signed [SW-1:0] in_data = '0;
  logic [3:0] tc_code = 4'd0;
  logic out_valid;
  logic signed [SW-1:0] out_data, offset_est;

  int checks = 0, errors = 0;
  longint m_acc = 0, m_est = 0;
  int m_tc = 0, m_out = 0;
  bit m_v = 0;

  always #2 clk = ~clk;

  dc_offset_loop #(.SW(SW), .TC_BASE(TCB), .LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .corr_en(corr_en), .freeze(freeze), .low_lat(low_lat), .tc_code(tc_code),
    .out_valid(out_valid), .out_data(out_data), .offset_est(offset_est)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return int'(v);
  endfunction

  // Behavioural reference: one update per rising edge.
  always @(posedge clk) begin
    longint x, nx;
    bit act;
    if (rst) begin
      m_acc = 0; m_est = 0; m_tc = 0; m_out = 0; m_v = 0;
    end else begin
      x   = longint'(in_data);
      act = corr_en && !low_lat;
      m_v = in_valid;
      m_out = act ? sat(x - m_est) : int'(x);
      if (!act) nx = 0;
      else if (in_valid && !freeze) begin
        nx = m_acc + (((x <<< FR) - m_acc) >>> (TCB + m_tc));
        if (nx > (longint'(LIM) <<< FR)) nx = longint'(LIM) <<< FR;
        if (nx < -(longint'(LIM) <<< FR)) nx = -(longint'(LIM) <<< FR);
      end else nx = m_acc;
      m_acc = nx;
      m_est = m_acc >>> FR;
      if (tc_code < 4'd12) m_tc = int'(tc_code);
    end
  end

  // Cycle-by-cycle comparison (R3 R4 R10), away from the rising edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 out_valid", longint'(out_valid), longint'(m_v));
      chk("R3 offset_est", longint'(offset_est), m_est);
      chk("R4 out_data", longint'(out_data), longint'(m_out));
    end
  end

  task automatic drive(input int n, input int base, input bit noisy, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_data  <= SW'(base + (noisy ? ((i * 7) % 3) - 1 : 0));
      in_valid <= gaps ? ((i % 7) != 6) : 1'b1;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int held;
    repeat (4) @(negedge clk);
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 out_data", longint'(out_data), 0);
    chk("R1 offset_est", longint'(offset_est), 0);
    rst <= 1'b0;
    @(negedge clk);
    chk("R1 est after reset", longint'(offset_est), 0);

    // R2: disabled, then enabled but blocked by low-latency mode
    drive(20, 300, 1'b1, 1'b0);
    corr_en <= 1'b1;
    drive(20, -500, 1'b1, 1'b1);
    @(negedge clk);
    chk("R2 est while low_lat", longint'(offset_est), 0);
    chk("R2 passthrough", longint'(out_data), longint'(in_data));

    // R9: converge with code 3 (32-cycle constant), gaps in the strobe
    low_lat <= 1'b0; tc_code <= 4'd3;
    drive(400, 37, 1'b1, 1'b1);
    @(negedge clk);
    chk("R9 converged", (offset_est >= 36 && offset_est <= 38) ? 1 : 0, 1);

    // R5: freeze holds the estimate while the input moves
    freeze <= 1'b1;
    @(negedge clk);
    held = int'(offset_est);
    drive(30, -50, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 held estimate", longint'(offset_est), longint'(held));
    chk("R5 still subtracted", longint'(out_data), longint'(-50 - held));

    // R6: latch code 1, then offer a reserved code
    freeze <= 1'b0; tc_code <= 4'd1;
    drive(5, 0, 1'b0, 1'b0);
    tc_code <= 4'd14;
    drive(12, 0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 reserved ignored", longint'(offset_est), m_est);
    chk("R6 est still moving", (offset_est < held) ? 1 : 0, 1);

    // R7: large offset clamps to LIMIT
    tc_code <= 4'd0;
    drive(80, 300, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 clamp high", longint'(offset_est), LIM);

    // R8: negative rail saturates, positive does not
    @(negedge clk); in_data <= SW'(MINV); freeze <= 1'b1;
    @(negedge clk);
    chk("R8 saturate low", longint'(out_data), MINV);
    in_data <= SW'(MAXV);
    @(negedge clk);
    chk("R8 no sat", longint'(out_data), MAXV - LIM);

    // R7: negative clamp
    freeze <= 1'b0;
    drive(80, -400, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 clamp low", longint'(offset_est), -LIM);
    in_data <= SW'(MAXV);
    @(negedge clk);
    chk("R8 saturate high", longint'(out_data), MAXV);

    // R2: disabling clears the estimate
    corr_en <= 1'b0;
    drive(2, 5, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 cleared", longint'(offset_est), 0);
    chk("R2 passthrough off", longint'(out_data), 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule